// File: doc/BRIEF.md
# Per-CPU Banked Level Interrupt Aggregator

This block gathers `N_WORDS` x 32 level-sensitive interrupt source lines and offers one private mask bank per processor (`N_CPU` banks). Each bank owns a mask bit for every source and a parent interrupt line of its own. That line is high when any source whose line is asserted is enabled in that bank. The source lines are synchronized into a status vector that all banks share. Each bank keeps its own mask words.

Software reaches the banks over a 32-bit register port with a valid/ready request channel and a valid/ready response channel. Every accepted request, read or write, yields exactly one response on the cycle after acceptance. A request is accepted only when no response is waiting, or when the waiting response is being taken in the same cycle. A response that is not taken holds its data until `rsp_ready` is high. Reads return data. Writes return a zero data word.

The address holds a bank index above a per-bank window of `N_WORDS` x 16 bytes. The window is rounded up to a power of two. Inside the window sit four register groups, each `N_WORDS` words long. In offset order they are: status, mask readback, mask set and mask clear.

Top module: `irq_bank_agg`

## Requirements
- R1: After reset every mask bit in every bank is 1. Every `irq_o` bit is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Within a bank window, the byte offset of group g for word w is (g*N_WORDS + w)*4. The groups are g=0 status, g=1 mask readback, g=2 mask set and g=3 mask clear. Bank c starts at byte c * 2^ceil(log2(N_WORDS*16)).
- R3: A write to a mask-set register sets each mask bit whose data bit is 1. Zero data bits leave the mask unchanged.
- R4: A write to a mask-clear register clears each mask bit whose data bit is 1. Zero data bits leave the mask unchanged.
- R5: A status bit follows its source line level 3 clock edges after a change (two synchronizer stages and the status register), with no latching. Bit i of status word w is source w*32+i.
- R6: `irq_o[c]` is registered. One cycle after any change of status or mask, it equals the OR over all sources of (status AND NOT mask of bank c).
- R7: A mask write to one bank leaves the masks and `irq_o` bit of every other bank unchanged.
- R8: A read of a mask-set or mask-clear register returns the current mask word. Writes to the status and mask-readback registers have no effect.
- R9: An access whose bank index is N_CPU or above, or whose offset lies past the four groups, reads as zero and changes no mask.
- R10: A request is accepted when `req_valid && req_ready`, and `req_ready` is low while `rsp_valid && !rsp_ready`. A response appears the cycle after acceptance and holds its data stable until taken. A write's response data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_WORDS*32 | Asynchronous level interrupt sources |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Register request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address (bank index above the window) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data, zero for writes and unmapped reads |
| irq_o | output | N_CPU | Registered parent interrupt, one per bank |

## Verification
The bench checks that a cleared mask bit raises the parent line exactly one cycle after the write. A design with an extra or a missing register stage would show the line early or late. Zero bits in set and clear writes must leave the mask unchanged; a design that loads the data word directly would wipe the other enables. Mask writes are aimed at one bank while the bench watches the other bank and an out-of-range bank index, which catches a bank decode that aliases or wraps. A stalled response is held with a second request already waiting, so a design that overwrote the response or accepted the request too early would return the wrong data.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int WORD_BITS = 32;
  localparam int MAX_WORDS = 8;
  localparam int N_GROUPS  = 4;

  typedef enum logic [1:0] {
    GRP_STATUS = 2'd0,
    GRP_MREAD  = 2'd1,
    GRP_MSET   = 2'd2,
    GRP_MCLR   = 2'd3
  } grp_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;
  logic [W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
      stat_q <= '0;
    end else begin
      meta_q <= async_i;
      hold_q <= meta_q;
      stat_q <= hold_q;
    end
  end

  assign sync_o = stat_q;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int N_WORDS = 2,
  parameter int WSEL_W  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_WORDS*32-1:0]   status_i,
  input  logic                    set_en,
  input  logic                    clr_en,
  input  logic [WSEL_W-1:0]       word_sel,
  input  logic [31:0]             wdata,
  output logic [N_WORDS*32-1:0]   mask_o,
  output logic                    irq_o
);
  logic [N_WORDS-1:0][31:0] mask_q;
  logic                     irq_q;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic hit;
    assign hit = (int'(word_sel) == w);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[w] <= '1;
      end else if (set_en && hit) begin
        mask_q[w] <= mask_q[w] | wdata;
      end else if (clr_en && hit) begin
        mask_q[w] <= mask_q[w] & ~wdata;
      end
    end
    assign mask_o[w*32 +: 32] = mask_q[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_i & ~mask_o);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_bank_agg.sv
module irq_bank_agg #(
  parameter int N_WORDS = 2,
  parameter int N_CPU   = 2,
  parameter int ADDR_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_WORDS*32-1:0]  src_i,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [31:0]            rsp_rdata,
  output logic [N_CPU-1:0]       irq_o
);
  import irq_agg_pkg::*;

  localparam int N_SRC  = N_WORDS * WORD_BITS;
  localparam int WIN_LG = $clog2(N_WORDS * 16);
  localparam int IDX_W  = WIN_LG - 2;
  localparam int BANK_W = ADDR_W - WIN_LG;
  localparam int WSEL_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [N_SRC-1:0]             status;
  logic [N_CPU*N_SRC-1:0]       mask_flat;
  logic [BANK_W-1:0]            bank;
  logic [IDX_W-1:0]             idx;
  grp_e                         grp;
  logic [WSEL_W-1:0]            word;
  logic                         bank_ok;
  logic                         in_win;
  logic                         accept;
  logic [N_SRC-1:0]             sel_mask;
  logic [31:0]                  rd_val;
  logic                         rsp_valid_q;
  logic [31:0]                  rsp_rdata_q;

  irq_sync #(.W(N_SRC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(src_i),
    .sync_o (status)
  );

  // address decode
  assign bank    = req_addr[ADDR_W-1:WIN_LG];
  assign idx     = req_addr[WIN_LG-1:2];
  assign bank_ok = int'(bank) < N_CPU;
  assign in_win  = int'(idx) < N_GROUPS * N_WORDS;
  assign grp     = grp_e'(2'(idx / IDX_W'(N_WORDS)));
  assign word    = WSEL_W'(idx % IDX_W'(N_WORDS));

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  for (genvar c = 0; c < N_CPU; c++) begin : g_bank
    logic hit;
    logic set_en;
    logic clr_en;
    assign hit    = accept && req_write && in_win && (int'(bank) == c);
    assign set_en = hit && (grp == GRP_MSET);
    assign clr_en = hit && (grp == GRP_MCLR);

    irq_mask_bank #(.N_WORDS(N_WORDS), .WSEL_W(WSEL_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .status_i(status),
      .set_en  (set_en),
      .clr_en  (clr_en),
      .word_sel(word),
      .wdata   (req_wdata),
      .mask_o  (mask_flat[c*N_SRC +: N_SRC]),
      .irq_o   (irq_o[c])
    );
  end

  // read mux
  always_comb begin
    sel_mask = '1;
    for (int c = 0; c < N_CPU; c++) begin
      if (int'(bank) == c) sel_mask = mask_flat[c*N_SRC +: N_SRC];
    end
    rd_val = '0;
    if (bank_ok && in_win) begin
      if (grp == GRP_STATUS) rd_val = status[int'(word)*32 +: 32];
      else                   rd_val = sel_mask[int'(word)*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= req_write ? 32'h0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/irq_bank_agg_chk.sv
module irq_bank_agg_chk #(
  parameter int N_WORDS = 2,
  parameter int N_CPU   = 2,
  parameter int ADDR_W  = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic                          req_write,
  input logic [ADDR_W-1:0]             req_addr,
  input logic                          rsp_valid,
  input logic                          rsp_ready,
  input logic [31:0]                   rsp_rdata,
  input logic [N_CPU-1:0]              irq_o,
  input logic [N_CPU*N_WORDS*32-1:0]   mask_flat
);
  localparam int WIN_LG = $clog2(N_WORDS * 16);

  logic acc;
  logic bad_bank;
  assign acc      = req_valid && req_ready;
  assign bad_bank = int'(req_addr >> WIN_LG) >= N_CPU;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R10

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R10

  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write |=> rsp_rdata == 32'h0); // R10

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !acc); // R10

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_flat) |=> (irq_o == '0)); // R6

  AST_BAD_BANK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bad_bank |=> $stable(mask_flat)); // R9
endmodule

bind irq_bank_agg irq_bank_agg_chk #(
  .N_WORDS(N_WORDS),
  .N_CPU  (N_CPU),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .irq_o    (irq_o),
  .mask_flat(mask_flat)
);

// File: tb/irq_bank_agg_tb.sv
module irq_bank_agg_tb;
  localparam int NW = 2;
  localparam int NC = 2;
  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NW*32-1:0] src_i = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [31:0]     rsp_rdata;
  logic [NC-1:0]   irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic        last_v;
  logic [31:0] last_d;

  always #4 clk = ~clk;

  irq_bank_agg #(.N_WORDS(NW), .N_CPU(NC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o)
  );

  function automatic logic [AW-1:0] ra(int cpu, int grp, int w);
    return AW'(cpu * 32 + (grp * NW + w) * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    last_v = rsp_valid; last_d = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [31:0] exp);
    access(1'b0, a, 32'h0);
    chk(req, {31'h0, last_v}, 32'h1);
    chk(req, last_d, exp);
  endtask

  task automatic t_reset();
    chk("R1 irq", {30'h0, irq_o}, 32'h0);
    chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rd_chk("R1 mask b0w0", ra(0, 1, 0), 32'hFFFF_FFFF);
    rd_chk("R1 mask b1w1", ra(1, 1, 1), 32'hFFFF_FFFF);
  endtask

  task automatic t_status();
    @(negedge clk);
    src_i = {32'h0000_0008, 32'hA5A5_0020};
    repeat (3) @(negedge clk);
    rd_chk("R5 R2 status w0", ra(0, 0, 0), 32'hA5A5_0020);
    rd_chk("R5 R2 status w1 bank1", ra(1, 0, 1), 32'h0000_0008);
    src_i[31:16] = 16'h0;
    repeat (3) @(negedge clk);
    rd_chk("R5 level drop", ra(0, 0, 0), 32'h0000_0020);
    chk("R5 still masked", {30'h0, irq_o}, 32'h0);
  endtask

  task automatic t_clear();
    access(1'b1, ra(0, 3, 0), 32'h0000_0020);
    chk("R6 irq not yet", {30'h0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R4 R6 irq one cycle later", {30'h0, irq_o}, 32'h1);
    rd_chk("R4 mask cleared", ra(0, 1, 0), 32'hFFFF_FFDF);
  endtask

  task automatic t_set();
    access(1'b1, ra(0, 2, 0), 32'h0000_0020);
    @(negedge clk);
    chk("R3 irq masked again", {30'h0, irq_o}, 32'h0);
    access(1'b1, ra(0, 3, 0), 32'h0000_0100);
    access(1'b1, ra(0, 2, 0), 32'h0);
    access(1'b1, ra(0, 3, 0), 32'h0);
    rd_chk("R3 zero bits keep mask", ra(0, 1, 0), 32'hFFFF_FEFF);
    rd_chk("R8 read via set reg", ra(0, 2, 0), 32'hFFFF_FEFF);
  endtask

  task automatic t_indep();
    access(1'b1, ra(1, 3, 1), 32'h0000_0008);
    @(negedge clk);
    chk("R7 only bank1 irq", {30'h0, irq_o}, 32'h2);
    rd_chk("R7 bank0 w1 untouched", ra(0, 1, 1), 32'hFFFF_FFFF);
    rd_chk("R7 bank1 w0 untouched", ra(1, 1, 0), 32'hFFFF_FFFF);
  endtask

  task automatic t_ignored();
    access(1'b1, ra(1, 1, 1), 32'hFFFF_FFFF);
    access(1'b1, ra(1, 0, 1), 32'hFFFF_FFFF);
    access(1'b1, ra(1, 1, 1), 32'h0);
    rd_chk("R8 read via clear reg", ra(1, 3, 1), 32'hFFFF_FFF7);
    chk("R8 irq unchanged", {30'h0, irq_o}, 32'h2);
  endtask

  task automatic t_badbank();
    access(1'b1, ra(2, 3, 0), 32'hFFFF_FFFF);
    access(1'b1, ra(3, 3, 1), 32'hFFFF_FFFF);
    rd_chk("R9 bad bank reads zero", ra(2, 1, 0), 32'h0);
    rd_chk("R9 bank0 w0 intact", ra(0, 1, 0), 32'hFFFF_FEFF);
    rd_chk("R9 bank1 w0 intact", ra(1, 1, 0), 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R9 irq intact", {30'h0, irq_o}, 32'h2);
  endtask

  task automatic t_wresp();
    access(1'b1, ra(0, 2, 1), 32'h1234_5678);
    chk("R10 write resp valid", {31'h0, last_v}, 32'h1);
    chk("R10 write resp zero", last_d, 32'h0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = ra(1, 1, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R10 rsp valid", {31'h0, rsp_valid}, 32'h1);
    chk("R10 ready low in stall", {31'h0, req_ready}, 32'h0);
    req_addr = ra(0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 held data", rsp_rdata, 32'hFFFF_FFF7);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second resp valid", {31'h0, rsp_valid}, 32'h1);
    chk("R10 second resp data", rsp_rdata, 32'h0000_0020);
    @(posedge clk);
    @(negedge clk);
    chk("R10 resp drained", {31'h0, rsp_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_clear();
    t_set();
    t_indep();
    t_ignored();
    t_badbank();
    t_wresp();
    t_backpressure();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule